// File: doc/BRIEF.md
# Reset-Cause Vector Generator

This block records why a chip was last restarted or disturbed, and it reports the most important of those reasons as one read-only vector word. Every source raises a one-cycle strobe. The strobe sets a sticky flag, and the flag stays set until software has read it out. The vector word holds an even code. The first source in priority order reports 02h, the next reports 04h, and so on. A word of 00h means that nothing is pending. Next to the code, a two-bit tag gives the severity class of the reported source: brownout-level, power-on-level or power-up-clear-level.

Software drains the causes by reading the word again and again. Each read takes the code that is on the output at that moment and clears only the flag behind it. The next read then returns the next pending cause, and an empty queue reads 00h. Three of the 23 flag positions are reserved: codes 10h, 12h and 2Eh. The block never produces these codes, and it never produces any code above 2Ch.

Top module: `rstvec_gen`

## Requirements
- R1: While the synchronous active-low reset is low, all flags are cleared. In the cycle after the reset is released, the outputs read code 00h and class 0.
- R2: With no flag set, the vector reads 00h and the class reads 0 (none). A read strobe given while nothing is pending has no effect.
- R3: A strobe on source index i (0 to 22), for any i that is not reserved, sets that flag at the next clock edge. If no flag of a lower index is pending, the vector then reads 2*(i+1), so index 0 gives 02h and index 21 gives 2Ch. The code is always even.
- R4: When several flags are pending, the vector reports the lowest index. A larger code therefore means a lower priority.
- R5: The class output uses 1 for brownout-level, 2 for power-on-level and 3 for power-up-clear-level. Codes 02h to 0Eh (indices 0 to 6) carry class 1. Code 14h (index 9) carries class 2. Codes 16h to 2Ch (indices 10 to 21) carry class 3.
- R6: Indices 7, 8 and 22 are reserved, and a strobe on any of them has no effect. The vector never shows 10h, 12h, 2Eh or any value from 30h upward.
- R7: A read strobe while a code is showing clears only the flag of that code. All other flags stay set, so the next read reports the next pending source.
- R8: If a strobe for the reported source arrives in the same cycle as a read strobe, that flag stays set and the same code is still showing afterwards.
- R9: A flag that is set stays set while no read strobe is given, and repeated strobes on it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_strobe | input | 23 | One-cycle event strobes, one bit per source index |
| rd_strobe | input | 1 | Read of the vector word; clears the flag of the reported code |
| vec_code | output | 8 | Even code of the highest-priority pending source, or 00h |
| vec_class | output | 2 | Reset class of the reported code: 0 none, 1 brownout, 2 power-on, 3 power-up-clear |

## Verification
The bench first walks a single strobe across every index. This isolates the code mapping and the class tag of each source, and it shows the three reserved positions to be inert. Directed multi-flag sets, drained one read at a time, show that the encoder picks the lowest index and that each read clears one flag only. A strobe that coincides with a read of the same flag separates set-wins from clear-wins. A constrained random phase then mixes sparse strobes with frequent reads against a reference model of the flag set. This exercises the cases where a strobe and a read of different flags fall in the same cycle.

// File: rtl/rstvec_pkg.sv
// Package: shared class encoding and index-to-class mapping for the
// reset-cause vector generator. Assumes the source index ranges are
// contiguous: brownout group first, then the single power-on source,
// then the power-up-clear group; every other index is reserved.
package rstvec_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_BOR  = 2'd1,
        CLS_POR  = 2'd2,
        CLS_PUC  = 2'd3
    } rst_class_e;

    // Map a source index to its reset class (CLS_NONE when reserved).
    function automatic rst_class_e class_of(input int idx, input int bor_last,
                                            input int por_idx, input int puc_first,
                                            input int puc_last);
        if (idx >= 0 && idx <= bor_last)          return CLS_BOR;
        if (idx == por_idx)                       return CLS_POR;
        if (idx >= puc_first && idx <= puc_last)  return CLS_PUC;
        return CLS_NONE;
    endfunction

    // Build the mask of indices that own a live (non-reserved) flag.
    function automatic logic [63:0] live_mask(input int nsrc, input int bor_last,
                                              input int por_idx, input int puc_first,
                                              input int puc_last);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < nsrc; i++) begin
            if (class_of(i, bor_last, por_idx, puc_first, puc_last) != CLS_NONE)
                m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rstvec_flag_bank.sv
// Sticky flag bank. One flop per live index, tied to zero for reserved
// ones. Set has priority over clear within a cycle. Assumes set and clear
// are single-cycle qualified vectors from the parent.
module rstvec_flag_bank #(
    parameter int unsigned        NUM_SRC   = 23,
    parameter logic [NUM_SRC-1:0] LIVE_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flag_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        if (LIVE_MASK[i]) begin : g_live
            logic q;
            // Hold the sticky flag: reset clears, strobe sets, read clears.
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= 1'b0;
                else if (set_i[i])  q <= 1'b1;
                else if (clr_i[i])  q <= 1'b0;
            end
            assign flag_o[i] = q;
        end else begin : g_rsv
            assign flag_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/rstvec_prio_enc.sv
// Fixed-priority encoder: index 0 wins. Produces a one-hot grant, the
// binary index of the winner and an any-pending flag. Purely combinational.
module rstvec_prio_enc #(
    parameter int unsigned NUM_SRC = 23,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);

    logic [NUM_SRC:0] lower_any;

    assign lower_any[0] = 1'b0;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign lower_any[i+1] = lower_any[i] | req_i[i];
        assign grant_o[i]     = req_i[i] & ~lower_any[i];
    end
    assign any_o = lower_any[NUM_SRC];

    // Convert the one-hot grant into a binary index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

endmodule

// File: rtl/rstvec_code_map.sv
// Turns the winning index into the even vector code and its class tag.
// Assumes idx_i is meaningful only while any_i is high; otherwise the
// outputs read 0 / CLS_NONE.
module rstvec_code_map
    import rstvec_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 23,
    parameter int unsigned CODE_W    = 8,
    parameter int          BOR_LAST  = 6,
    parameter int          POR_IDX   = 9,
    parameter int          PUC_FIRST = 10,
    parameter int          PUC_LAST  = 21,
    localparam int unsigned IDX_W    = $clog2(NUM_SRC)
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              any_i,
    output logic [CODE_W-1:0] code_o,
    output rst_class_e        class_o
);

    // Code is twice the one-based index; zero when idle.
    always_comb begin
        if (any_i) code_o = CODE_W'((int'(idx_i) + 1) * 2);
        else       code_o = '0;
    end

    // Look up the class of the winning index.
    always_comb begin
        class_o = CLS_NONE;
        if (any_i) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (int'(idx_i) == i)
                    class_o = class_of(i, BOR_LAST, POR_IDX, PUC_FIRST, PUC_LAST);
            end
        end
    end

endmodule

// File: rtl/rstvec_gen.sv
// Reset-cause vector generator top. Latches event strobes into sticky
// flags, reports the lowest-index pending flag as an even code with its
// reset class, and on a read clears only the reported flag. Assumes
// rd_strobe is a one-cycle pulse per bus read; outputs are combinational
// from the flag register.
module rstvec_gen
    import rstvec_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 23,
    parameter int unsigned CODE_W    = 8,
    parameter int          BOR_LAST  = 6,
    parameter int          POR_IDX   = 9,
    parameter int          PUC_FIRST = 10,
    parameter int          PUC_LAST  = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_strobe,
    input  logic               rd_strobe,
    output logic [CODE_W-1:0]  vec_code,
    output logic [1:0]         vec_class
);

    localparam int unsigned IDX_W = $clog2(NUM_SRC);
    localparam logic [NUM_SRC-1:0] LIVE = NUM_SRC'(live_mask(NUM_SRC, BOR_LAST,
                                                   POR_IDX, PUC_FIRST, PUC_LAST));

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] clr_vec;
    logic [IDX_W-1:0]   win_idx;
    logic               any_pend;
    rst_class_e         win_class;

    // Clear only the granted flag, and only on a read.
    assign clr_vec = rd_strobe ? grant : '0;

    rstvec_flag_bank #(
        .NUM_SRC   (NUM_SRC),
        .LIVE_MASK (LIVE)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_strobe),
        .clr_i  (clr_vec),
        .flag_o (flag_q)
    );

    rstvec_prio_enc #(
        .NUM_SRC (NUM_SRC)
    ) u_enc (
        .req_i   (flag_q),
        .grant_o (grant),
        .idx_o   (win_idx),
        .any_o   (any_pend)
    );

    rstvec_code_map #(
        .NUM_SRC   (NUM_SRC),
        .CODE_W    (CODE_W),
        .BOR_LAST  (BOR_LAST),
        .POR_IDX   (POR_IDX),
        .PUC_FIRST (PUC_FIRST),
        .PUC_LAST  (PUC_LAST)
    ) u_map (
        .idx_i   (win_idx),
        .any_i   (any_pend),
        .code_o  (vec_code),
        .class_o (win_class)
    );

    assign vec_class = win_class;

endmodule

// File: rtl/rstvec_gen_chk.sv
// Checker for rstvec_gen: relates the flag register to the vector and
// class outputs and to the strobes over time. Attached by bind below.
module rstvec_gen_chk #(
    parameter int unsigned NUM_SRC   = 23,
    parameter int unsigned CODE_W    = 8,
    parameter int          POR_IDX   = 9,
    parameter int          PUC_LAST  = 21
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_strobe,
    input logic               rd_strobe,
    input logic [NUM_SRC-1:0] flags,
    input logic [CODE_W-1:0]  vec_code,
    input logic [1:0]         vec_class
);

    localparam logic [NUM_SRC-1:0] RSV = NUM_SRC'((64'd1 << 7) | (64'd1 << 8) | (64'd1 << 22));

    logic [NUM_SRC-1:0] cur_mask;

    // One-hot mask of the flag named by the shown code.
    always_comb begin
        if (vec_code == '0) cur_mask = '0;
        else                cur_mask = NUM_SRC'(1) << (int'(vec_code[CODE_W-1:1]) - 1);
    end

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> (vec_code == '0 && vec_class == 2'd0));

    p_even_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_code[0] == 1'b0);

    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> ((flags & cur_mask) != '0 && (flags & (cur_mask - 1'b1)) == '0));

    p_por_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code == CODE_W'((POR_IDX + 1) * 2)) |-> (vec_class == 2'd2));

    p_no_rsv_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_mask & RSV) == '0) && (vec_code <= CODE_W'((PUC_LAST + 1) * 2)));

    p_one_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && vec_code != '0 && evt_strobe == '0)
        |=> ($countones(flags) + 1 == $countones($past(flags))));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && vec_code != '0 && evt_strobe == cur_mask)
        |=> (flags == $past(flags)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ((flags & $past(flags)) == $past(flags)));

endmodule

bind rstvec_gen rstvec_gen_chk #(
    .NUM_SRC  (NUM_SRC),
    .CODE_W   (CODE_W),
    .POR_IDX  (POR_IDX),
    .PUC_LAST (PUC_LAST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt_strobe),
    .rd_strobe  (rd_strobe),
    .flags      (flag_q),
    .vec_code   (vec_code),
    .vec_class  (vec_class)
);

// File: tb/rstvec_gen_tb.sv
module rstvec_gen_tb;

    localparam logic [22:0] RSV = (23'd1 << 7) | (23'd1 << 8) | (23'd1 << 22);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [22:0] evt = '0;
    logic        rd = 1'b0;
    logic [7:0]  vec_code;
    logic [1:0]  vec_class;
    logic [22:0] mdl = '0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    rstvec_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_strobe (evt),
        .rd_strobe  (rd),
        .vec_code   (vec_code),
        .vec_class  (vec_class)
    );

    function automatic logic [7:0] exp_code(input logic [22:0] f);
        for (int i = 0; i < 23; i++) if (f[i]) return 8'((i + 1) * 2);
        return 8'h00;
    endfunction

    function automatic logic [1:0] exp_class(input logic [7:0] c);
        int idx;
        if (c == 8'h00) return 2'd0;
        idx = int'(c) / 2 - 1;
        if (idx <= 6) return 2'd1;
        if (idx == 9) return 2'd2;
        if (idx >= 10 && idx <= 21) return 2'd3;
        return 2'd0;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Compare both outputs with the model; class tagged R5.
    task automatic chk_out(input string tag);
        logic [7:0] c;
        c = exp_code(mdl);
        chk(tag, vec_code, c);
        chk("R5", {6'd0, vec_class}, {6'd0, exp_class(c)});
    endtask

    // Drive one cycle from a negedge, update the model, return at next negedge.
    task automatic step(input logic [22:0] e, input logic r);
        logic [7:0]  c;
        logic [22:0] g;
        evt = e;
        rd  = r;
        c = exp_code(mdl);
        g = (c == 8'h00) ? 23'd0 : (23'd1 << (int'(c) / 2 - 1));
        @(posedge clk);
        mdl = (mdl & ~(r ? g : 23'd0)) | (e & ~RSV);
        @(negedge clk);
        evt = '0;
        rd  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        mdl = '0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        chk("R1", vec_code, 8'h00);
        chk("R1", {6'd0, vec_class}, 8'h00);

        // R2: idle read has no effect
        step('0, 1'b1);
        chk_out("R2");
        step('0, 1'b0);
        chk_out("R2");

        // R3 / R6 / R5: walk a single strobe over every index, then drain
        for (int i = 0; i < 23; i++) begin
            step(23'd1 << i, 1'b0);
            chk_out(RSV[i] ? "R6" : "R3");
            step('0, 1'b1);
            chk_out("R7");
        end

        // R4 / R7: three flags, drained in priority order
        step((23'd1 << 15) | (23'd1 << 3) | (23'd1 << 20), 1'b0);
        chk("R4", vec_code, 8'h08);
        step('0, 1'b1);
        chk("R7", vec_code, 8'h20);
        step('0, 1'b1);
        chk("R7", vec_code, 8'h2A);
        step('0, 1'b1);
        chk("R7", vec_code, 8'h00);

        // R8: strobe collides with read of the same flag
        step(23'd1 << 5, 1'b0);
        step(23'd1 << 5, 1'b1);
        chk("R8", vec_code, 8'h0C);
        step('0, 1'b1);
        chk("R8", vec_code, 8'h00);

        // R9: stickiness and repeated strobes
        step(23'd1 << 12, 1'b0);
        for (int k = 0; k < 5; k++) step('0, 1'b0);
        step(23'd1 << 12, 1'b0);
        chk("R9", vec_code, 8'h1A);

        // R6: reserved strobe below a live flag changes nothing
        step(RSV, 1'b0);
        chk("R6", vec_code, 8'h1A);
        step('0, 1'b1);
        chk("R6", vec_code, 8'h00);

        // R1: reset in mid-run clears pending flags
        step((23'd1 << 0) | (23'd1 << 9), 1'b0);
        chk("R5", {6'd0, vec_class}, 8'h01);
        do_reset();
        chk("R1", vec_code, 8'h00);

        // R4 / R7 / R8: random strobes and reads against the model
        for (int n = 0; n < 600; n++) begin
            logic [22:0] e;
            e = 23'($urandom) & 23'($urandom) & 23'($urandom);
            step(e, ($urandom % 3) == 0);
            chk_out("R4");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule